// File: doc/BRIEF.md
# Page Table Entry Permission Checker

This unit sits beside a page-walk engine in a virtual-memory translation path. At each walk step it takes the 8-bit attribute byte of the entry just read, along with the requested access kind, the current privilege level and the two status controls. The first control, make-executable-readable, lets execute-only pages be read. The second, supervisor-user-access, lets supervisor data accesses reach user pages. From these it decides whether the entry points to the next table level, is malformed, or is a leaf. For a leaf it decides whether the access is allowed.

When an allowed leaf still has its accessed flag clear, or a store-type access finds its dirty flag clear, the unit produces the rewritten attribute byte. Any failure becomes a 3-bit walk-error cause and an architectural exception number. The walk engine may also hand in an error it found itself, such as a bus error on the entry fetch, a misaligned large page, or an update it is not allowed to make. The unit then only classifies that error.

Requests use a valid/ready handshake. Each accepted request gives one registered result one cycle later, and the result is held while the consumer stalls.

Top module: `pte_perm_unit`

## Requirements
- R1: Attribute bit positions are V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7. An entry is `malformed` when V=0, or when W=1 with R=0. A non-malformed entry is a `pointer` when R, W and X are all 0, and a `leaf` otherwise. Exactly one of the three class outputs is high with each result.
- R2: Privilege encoding: 0 user, 1 supervisor, 3 machine. Access encoding: 0 read, 1 write, 2 atomic read-modify-write, 3 execute. In user mode every access needs U=1. A read needs R=1, or X=1 with make-executable-readable set. A write needs W=1. A read-modify-write needs both the write and the read condition. An execute needs X=1.
- R3: In supervisor mode, read, write and read-modify-write need U=0 unless supervisor-user-access is set, with the same R/W/X conditions as R2. An execute needs U=0 and X=1 whatever supervisor-user-access says.
- R4: Privilege 3 or the reserved value 2 raises `internal_error`, keeps `permit` and `update_valid` low, and raises no fault of its own.
- R5: `update_valid` is high only for a permitted leaf with A=0, or a permitted leaf reached by a write or read-modify-write with D=0. The rewritten byte then has A=1, and has D=1 only for a write or read-modify-write. All other bits are unchanged. Without an update, `pte_new` equals the input byte.
- R6: Cause codes are 0 memory access error, 1 malformed entry, 2 no permission, 3 misaligned superpage, 4 update needed but not enabled. An external walk error wins, reports its own code, and forces `permit` and `update_valid` low. Otherwise, in user or supervisor mode, a malformed entry gives cause 1 and a denied leaf gives cause 2. A pointer or a permitted leaf gives no fault.
- R7: The exception number is 0 without a fault. Cause 0 gives an access fault: 1 for execute, 5 for read, 7 for write or read-modify-write. Any other cause gives a page fault: 12 for execute, 13 for read, 15 for write or read-modify-write.
- R8: A request is accepted when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R9: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| pte_attr | input | 8 | Entry attribute byte |
| acc_type | input | 2 | Access kind |
| priv | input | 2 | Privilege level |
| mxr | input | 1 | Make-executable-readable control |
| sum | input | 1 | Supervisor-user-access control |
| walk_err_valid | input | 1 | Walk engine reports its own error |
| walk_err_code | input | 3 | Cause code of that error |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| is_pointer | output | 1 | Entry points to the next level |
| is_malformed | output | 1 | Entry is malformed |
| is_leaf | output | 1 | Entry is a leaf |
| permit | output | 1 | Access allowed |
| update_valid | output | 1 | A/D rewrite required |
| pte_new | output | 8 | Rewritten attribute byte |
| internal_error | output | 1 | Unsupported privilege for this check |
| fault | output | 1 | Walk step fails |
| err_cause | output | 3 | Failure cause code |
| exc_code | output | 5 | Exception number |

## Verification
Every result comes out of a single register stage. Each output is therefore due exactly one clock edge after the request is accepted. The bench drives a new request on a falling edge and compares all outputs on the next falling edge, with `out_ready` held high, so one result is checked per cycle across the full sweep of attribute bytes, access kinds, privileges and control bits. The stall test drops `out_ready` and compares the held outputs on two later falling edges. It then raises `out_ready` and expects the waiting request's result one edge after the accept.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;

  localparam int ATTR_W = 8;
  localparam int CAUSE_W = 3;
  localparam int EXC_W = 5;

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_G = 5;
  localparam int B_A = 6;
  localparam int B_D = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RMW   = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_MEM      = 3'd0,
    CZ_BADPTE   = 3'd1,
    CZ_DENIED   = 3'd2,
    CZ_MISALIGN = 3'd3,
    CZ_NOUPD    = 3'd4
  } cause_e;

  localparam logic [EXC_W-1:0] EXC_NONE     = 5'd0;
  localparam logic [EXC_W-1:0] EXC_FETCH_AF = 5'd1;
  localparam logic [EXC_W-1:0] EXC_LOAD_AF  = 5'd5;
  localparam logic [EXC_W-1:0] EXC_STORE_AF = 5'd7;
  localparam logic [EXC_W-1:0] EXC_FETCH_PF = 5'd12;
  localparam logic [EXC_W-1:0] EXC_LOAD_PF  = 5'd13;
  localparam logic [EXC_W-1:0] EXC_STORE_PF = 5'd15;

  function automatic logic f_malformed(input logic [ATTR_W-1:0] a);
    return !a[B_V] || (a[B_W] && !a[B_R]);
  endfunction

  function automatic logic f_no_leaf_perm(input logic [ATTR_W-1:0] a);
    return !(a[B_R] || a[B_W] || a[B_X]);
  endfunction

  function automatic logic f_store_kind(input acc_e k);
    return (k == ACC_WRITE) || (k == ACC_RMW);
  endfunction

  function automatic logic f_readable(input logic [ATTR_W-1:0] a, input logic mx);
    return a[B_R] || (a[B_X] && mx);
  endfunction

  // Per-access R/W/X condition, before any U-bit test.
  function automatic logic f_kind_ok(input logic [ATTR_W-1:0] a, input acc_e k,
                                     input logic mx);
    unique case (k)
      ACC_READ:  return f_readable(a, mx);
      ACC_WRITE: return a[B_W];
      ACC_RMW:   return a[B_W] && f_readable(a, mx);
      default:   return a[B_X];
    endcase
  endfunction

  function automatic logic f_user_bit_ok(input logic [ATTR_W-1:0] a, input acc_e k,
                                         input lvl_e l, input logic su);
    if (l == LVL_USER) return a[B_U];
    if (k == ACC_EXEC) return !a[B_U];
    return !a[B_U] || su;
  endfunction

  function automatic logic [ATTR_W-1:0] f_rewrite(input logic [ATTR_W-1:0] a,
                                                  input acc_e k);
    logic [ATTR_W-1:0] r;
    r = a;
    r[B_A] = 1'b1;
    if (f_store_kind(k)) r[B_D] = 1'b1;
    return r;
  endfunction

  function automatic logic [EXC_W-1:0] f_exc(input acc_e k, input logic [CAUSE_W-1:0] c);
    logic acc_fault;
    acc_fault = (c == CZ_MEM);
    unique case (k)
      ACC_EXEC: return acc_fault ? EXC_FETCH_AF : EXC_FETCH_PF;
      ACC_READ: return acc_fault ? EXC_LOAD_AF  : EXC_LOAD_PF;
      default:  return acc_fault ? EXC_STORE_AF : EXC_STORE_PF;
    endcase
  endfunction

endpackage

// File: rtl/pte_classify.sv
module pte_classify
  import pte_perm_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  output logic              cls_pointer,
  output logic              cls_malformed,
  output logic              cls_leaf
);
  always_comb begin
    cls_malformed = f_malformed(attr);
    cls_pointer   = !cls_malformed && f_no_leaf_perm(attr);
    cls_leaf      = !cls_malformed && !cls_pointer;
  end
endmodule

// File: rtl/pte_rules.sv
module pte_rules
  import pte_perm_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  acc_e              kind,
  input  lvl_e              lvl,
  input  logic              mx,
  input  logic              su,
  input  logic              leaf,
  input  logic              ext_err,
  output logic              lvl_bad,
  output logic              allow,
  output logic              upd_need,
  output logic [ATTR_W-1:0] attr_next
);
  logic rule_ok;
  logic ad_stale;

  always_comb begin
    lvl_bad  = (lvl == LVL_MACH) || (lvl == LVL_RSVD);
    rule_ok  = f_kind_ok(attr, kind, mx) && f_user_bit_ok(attr, kind, lvl, su);
    allow    = leaf && !lvl_bad && !ext_err && rule_ok;
    ad_stale = !attr[B_A] || (f_store_kind(kind) && !attr[B_D]);
    upd_need = allow && ad_stale;
    attr_next = upd_need ? f_rewrite(attr, kind) : attr;
  end
endmodule

// File: rtl/pte_fault_map.sv
module pte_fault_map
  import pte_perm_pkg::*;
(
  input  logic               ext_err,
  input  logic [CAUSE_W-1:0] ext_code,
  input  logic               malformed,
  input  logic               leaf,
  input  logic               allow,
  input  logic               lvl_bad,
  input  acc_e               kind,
  output logic               flt,
  output logic [CAUSE_W-1:0] cause,
  output logic [EXC_W-1:0]   exc
);
  always_comb begin
    flt   = 1'b0;
    cause = '0;
    if (ext_err) begin
      flt   = 1'b1;
      cause = ext_code;
    end else if (!lvl_bad && malformed) begin
      flt   = 1'b1;
      cause = CZ_BADPTE;
    end else if (!lvl_bad && leaf && !allow) begin
      flt   = 1'b1;
      cause = CZ_DENIED;
    end
    exc = flt ? f_exc(kind, cause) : EXC_NONE;
  end
endmodule

// File: rtl/pte_perm_unit.sv
module pte_perm_unit
  import pte_perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ATTR_W-1:0]  pte_attr,
  input  logic [1:0]         acc_type,
  input  logic [1:0]         priv,
  input  logic               mxr,
  input  logic               sum,
  input  logic               walk_err_valid,
  input  logic [CAUSE_W-1:0] walk_err_code,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               is_pointer,
  output logic               is_malformed,
  output logic               is_leaf,
  output logic               permit,
  output logic               update_valid,
  output logic [ATTR_W-1:0]  pte_new,
  output logic               internal_error,
  output logic               fault,
  output logic [CAUSE_W-1:0] err_cause,
  output logic [EXC_W-1:0]   exc_code
);
  acc_e kind;
  lvl_e lvl;
  assign kind = acc_e'(acc_type);
  assign lvl  = lvl_e'(priv);

  logic c_pointer, c_malformed, c_leaf;
  logic c_lvl_bad, c_allow, c_upd;
  logic [ATTR_W-1:0] c_attr_next;
  logic c_flt;
  logic [CAUSE_W-1:0] c_cause;
  logic [EXC_W-1:0] c_exc;
  logic accept;

  pte_classify u_cls (
    .attr(pte_attr), .cls_pointer(c_pointer),
    .cls_malformed(c_malformed), .cls_leaf(c_leaf)
  );

  pte_rules u_rules (
    .attr(pte_attr), .kind(kind), .lvl(lvl), .mx(mxr), .su(sum),
    .leaf(c_leaf), .ext_err(walk_err_valid), .lvl_bad(c_lvl_bad),
    .allow(c_allow), .upd_need(c_upd), .attr_next(c_attr_next)
  );

  pte_fault_map u_flt (
    .ext_err(walk_err_valid), .ext_code(walk_err_code),
    .malformed(c_malformed), .leaf(c_leaf), .allow(c_allow),
    .lvl_bad(c_lvl_bad), .kind(kind), .flt(c_flt),
    .cause(c_cause), .exc(c_exc)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      is_pointer     <= 1'b0;
      is_malformed   <= 1'b0;
      is_leaf        <= 1'b0;
      permit         <= 1'b0;
      update_valid   <= 1'b0;
      pte_new        <= '0;
      internal_error <= 1'b0;
      fault          <= 1'b0;
      err_cause      <= '0;
      exc_code       <= '0;
    end else if (accept) begin
      out_valid      <= 1'b1;
      is_pointer     <= c_pointer;
      is_malformed   <= c_malformed;
      is_leaf        <= c_leaf;
      permit         <= c_allow;
      update_valid   <= c_upd;
      pte_new        <= c_attr_next;
      internal_error <= c_lvl_bad;
      fault          <= c_flt;
      err_cause      <= c_cause;
      exc_code       <= c_exc;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end
endmodule

// File: rtl/pte_perm_unit_chk.sv
module pte_perm_unit_chk
  import pte_perm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               is_pointer,
  input logic               is_malformed,
  input logic               is_leaf,
  input logic               permit,
  input logic               update_valid,
  input logic [ATTR_W-1:0]  pte_new,
  input logic               internal_error,
  input logic               fault,
  input logic [CAUSE_W-1:0] err_cause,
  input logic [EXC_W-1:0]   exc_code
);
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({is_pointer, is_malformed, is_leaf}) == 1); // R1
  AST_PERMIT_NEEDS_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && permit |-> is_leaf && !fault); // R2
  AST_MACHINE_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && internal_error |-> !permit && !update_valid); // R4
  AST_UPDATE_SETS_A: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && update_valid |-> pte_new[B_A] && permit); // R5
  AST_NOFAULT_NOEXC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fault |-> exc_code == '0); // R7
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(pte_new) && $stable(exc_code)
      && $stable(permit) && $stable(err_cause)); // R8
endmodule

bind pte_perm_unit pte_perm_unit_chk u_chk (.*);

// File: tb/pte_perm_unit_tb_top.sv
module pte_perm_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] pte_attr = '0;
  logic [1:0] acc_type = '0;
  logic [1:0] priv = '0;
  logic mxr = 1'b0;
  logic sum = 1'b0;
  logic walk_err_valid = 1'b0;
  logic [2:0] walk_err_code = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic is_pointer, is_malformed, is_leaf, permit, update_valid;
  logic [7:0] pte_new;
  logic internal_error, fault;
  logic [2:0] err_cause;
  logic [4:0] exc_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pte_perm_unit dut_i (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (attr=%02h acc=%0d priv=%0d mxr=%0d sum=%0d)",
               req, what, act, exp, pte_attr, acc_type, priv, mxr, sum);
    end
  endtask

  // Bench-side model computed straight from the requirement text.
  task automatic check_outputs();
    bit v, r, w, x, u, a, d;
    bit bad, ptr, leaf, rd, ok, storek, idle, perm, upd, flt;
    int cause, exc, newb;
    v = pte_attr[0]; r = pte_attr[1]; w = pte_attr[2]; x = pte_attr[3];
    u = pte_attr[4]; a = pte_attr[6]; d = pte_attr[7];
    bad = (v == 0) || (w && !r);
    ptr = !bad && !(r | w | x);
    leaf = !bad && !ptr;
    rd = r || (x && mxr);
    storek = (acc_type == 1) || (acc_type == 2);
    idle = (priv >= 2);
    case (acc_type)
      0: ok = rd;
      1: ok = w;
      2: ok = w && rd;
      default: ok = x;
    endcase
    if (priv == 0) ok = ok && u;
    else if (acc_type == 3) ok = ok && !u;
    else ok = ok && (!u || sum);
    perm = leaf && !idle && !walk_err_valid && ok;
    upd = perm && (!a || (storek && !d));
    newb = pte_attr;
    if (upd) begin
      newb = newb | 8'h40;
      if (storek) newb = newb | 8'h80;
    end
    flt = 1'b1;
    if (walk_err_valid) cause = walk_err_code;
    else if (!idle && bad) cause = 1;
    else if (!idle && leaf && !perm) cause = 2;
    else begin flt = 1'b0; cause = 0; end
    if (!flt) exc = 0;
    else if (acc_type == 3) exc = (cause == 0) ? 1 : 12;
    else if (acc_type == 0) exc = (cause == 0) ? 5 : 13;
    else exc = (cause == 0) ? 7 : 15;

    check("R8", "out_valid", out_valid, 1);
    check("R1", "class", {is_pointer, is_malformed, is_leaf}, {ptr, bad, leaf});
    if (priv == 0) check("R2", "permit", permit, perm);
    else if (priv == 1) check("R3", "permit", permit, perm);
    else check("R4", "permit", permit, perm);
    check("R4", "internal_error", internal_error, idle);
    check("R5", "update_valid", update_valid, upd);
    check("R5", "pte_new", pte_new, newb);
    check("R6", "fault", fault, flt);
    check("R6", "err_cause", err_cause, cause);
    check("R7", "exc_code", exc_code, exc);
  endtask

  initial begin : watchdog
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] held;
    repeat (2) @(negedge clk);
    check("R9", "out_valid after reset", out_valid, 0);
    check("R8", "in_ready after reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "out_valid idle", out_valid, 0);

    // Full sweep: every attribute byte, access kind, privilege, control pair.
    for (int p = 0; p < 4; p++) begin
      if (p == 2 && 0) continue;
      for (int k = 0; k < 4; k++) begin
        for (int c = 0; c < 4; c++) begin
          for (int b = 0; b < 256; b++) begin
            pte_attr = 8'(b); acc_type = 2'(k); priv = 2'(p);
            mxr = c[0]; sum = c[1]; in_valid = 1'b1;
            @(negedge clk);
            check_outputs();
          end
        end
      end
    end

    // External walk errors over every code and access kind.
    walk_err_valid = 1'b1;
    for (int e = 0; e < 8; e++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 2; p++) begin
          walk_err_code = 3'(e); acc_type = 2'(k); priv = 2'(p);
          pte_attr = 8'h1F; mxr = 1'b0; sum = 1'b0;
          @(negedge clk);
          check_outputs();
        end
      end
    end
    walk_err_valid = 1'b0;

    // Stall: result of the first request is held, second waits.
    pte_attr = 8'h0B; acc_type = 2'd0; priv = 2'd1; mxr = 1'b0; sum = 1'b0;
    @(negedge clk);
    check_outputs();
    held = pte_new;
    out_ready = 1'b0;
    pte_attr = 8'h57; acc_type = 2'd1; priv = 2'd0;
    @(negedge clk);
    check("R8", "in_ready while stalled", in_ready, 0);
    check("R8", "held pte_new", pte_new, held);
    check("R8", "held exc_code", exc_code, 0);
    @(negedge clk);
    check("R8", "held out_valid", out_valid, 1);
    check("R8", "held pte_new again", pte_new, held);
    out_ready = 1'b1;
    @(negedge clk);
    check_outputs();
    in_valid = 1'b0;
    @(negedge clk);
    check("R8", "out_valid drops after drain", out_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule